// File: doc/BRIEF.md
# Timer Count-Strobe Front End

This block sits ahead of a low-power timer's counter and decides when the counter should advance. It picks one of four clock-enable strobes. It then produces a one-cycle `tick` by one of four methods:

- dividing the strobe rate by a power of two;
- passing every strobe through unchanged;
- detecting rising edges on a pulse input;
- passing pulse-input changes through a debounce filter clocked by the chosen strobe.

One 4-bit scale field, `scale` (N below), does double duty:

- As a divider it gives a ratio of 2^(N+1).
- As a filter it sets how many strobes, 2^N, a new input level must survive before it is taken. N = 0 is not a valid filter width. In that case the input is used unfiltered.

Everything runs on one system clock. The selectable clocks arrive as single-cycle enables. The pulse input comes in already synchronised and already corrected for polarity, with high meaning active. Dropping `run` clears all internal state. Configuration is meant to be changed only while `run` is low.

Top module: `strobe_prescaler`

## Requirements

The timing rules below use one shared convention. An input is sampled at a rising clock edge. `tick` is registered, so it is high for the one cycle that follows that edge.

- R1: While reset is active or `run` is low, `tick` stays 0 and the divider and filter state clear. The first tick after `run` rises therefore needs a full period.
- R2: Only the strobe indexed by `clk_sel` (0 to 3, bit i of `src_en` is source i) advances the block. Strobes on the other three sources have no effect on `tick`.
- R3: With `pulse_mode`=0 and `bypass`=0, `tick` pulses once for every 2^(N+1) selected strobes. The first pulse follows the 2^(N+1)-th strobe after enabling.
- R4: With `pulse_mode`=0 and `bypass`=1, every selected strobe gives a tick in the following cycle, whatever N is.
- R5: With `pulse_mode`=1 and `bypass`=1, each rising edge of `pulse_in` gives one tick. The tick comes in the cycle after `pulse_in` is first sampled high.
- R6: With `pulse_mode`=1, `bypass`=0 and N=0, the block behaves exactly as in R5.
- R7: With `pulse_mode`=1, `bypass`=0 and N>0, a new `pulse_in` level is accepted only after 2^N selected strobes during which it differs from the accepted level. Accepting a high level gives a tick in the cycle after the last of those strobes.
- R8: If `pulse_in` returns to the accepted level before acceptance, the filter count restarts from zero.
- R9: An accepted transition to low produces no tick, and the next rise again needs the full 2^N strobes.
- R10: Outside time-mode bypass, `tick` is never high in two consecutive cycles.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enable; low clears all internal state |
| src_en | input | 4 | Four clock-enable strobes, one per selectable source |
| clk_sel | input | 2 | Index of the strobe that drives the block |
| pulse_mode | input | 1 | 0 = divide the strobe, 1 = count pulse-input edges |
| bypass | input | 1 | Skip the divider or filter |
| scale | input | 4 | Divider exponent minus one, or filter exponent |
| pulse_in | input | 1 | Synchronous, active-high pulse input |
| tick | output | 1 | One-cycle count strobe |

## Verification

The properties assume the following about the inputs:

- `clk_sel`, `pulse_mode`, `bypass` and `scale` do not change in the cycle after they are used while `run` is high.
- `pulse_in` is already synchronous to `clk`.

Read that way, a check such as "a selected strobe in bypass is followed by a tick" holds even though it looks at the configuration of only one cycle. The bench respects these assumptions. It changes configuration only inside a task that lowers `run` first. It drives strobes and `pulse_in` only at falling clock edges.

// File: rtl/strobe_prescaler.sv
module strobe_prescaler #(
  parameter int SRC_N   = 4,
  parameter int SEL_W   = $clog2(SRC_N),
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [SRC_N-1:0]   src_en,
  input  logic [SEL_W-1:0]   clk_sel,
  input  logic               pulse_mode,
  input  logic               bypass,
  input  logic [SCALE_W-1:0] scale,
  input  logic               pulse_in,
  output logic               tick
);
  localparam int CNT_W = 1 << SCALE_W;
  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;
  logic             acc;

  wire             stb    = src_en[clk_sel];
  wire             direct = bypass | (pulse_mode & (scale == '0));
  wire [SCALE_W:0] sh     = pulse_mode ? {1'b0, scale}
                                       : {1'b0, scale} + (SCALE_W+1)'(1);
  wire [CNT_W:0]   lim    = (ONE << sh) - ONE;
  wire             hit    = ({1'b0, cnt} == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      acc  <= 1'b0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      acc  <= pulse_in;
      tick <= 1'b0;
    end else if (!pulse_mode) begin
      acc  <= pulse_in;
      tick <= 1'b0;
      if (direct) begin
        cnt  <= '0;
        tick <= stb;
      end else if (stb) begin
        if (hit) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (direct) begin
      cnt  <= '0;
      acc  <= pulse_in;
      tick <= pulse_in & ~acc;
    end else begin
      tick <= 1'b0;
      if (pulse_in == acc) begin
        cnt <= '0;
      end else if (stb) begin
        if (hit) begin
          cnt  <= '0;
          acc  <= pulse_in;
          tick <= pulse_in;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/strobe_prescaler_chk.sv
module strobe_prescaler_chk #(
  parameter int SRC_N   = 4,
  parameter int SEL_W   = 2,
  parameter int SCALE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run,
  input logic [SRC_N-1:0]   src_en,
  input logic [SEL_W-1:0]   clk_sel,
  input logic               pulse_mode,
  input logic               bypass,
  input logic [SCALE_W-1:0] scale,
  input logic               pulse_in,
  input logic               tick
);
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);

  p_no_source_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pulse_mode && !src_en[clk_sel]) |=> !tick);

  p_bypass_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pulse_mode && bypass && src_en[clk_sel]) |=> tick);

  p_pulse_tick_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pulse_mode) |-> $past(pulse_in));

  p_filter_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pulse_mode && !bypass && scale != '0) |-> ($past(pulse_in) && $past(pulse_in, 2)));

  p_single_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (pulse_mode || !bypass)) |=> !tick);
endmodule

bind strobe_prescaler strobe_prescaler_chk #(.SRC_N(SRC_N), .SEL_W(SEL_W), .SCALE_W(SCALE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .src_en(src_en), .clk_sel(clk_sel),
  .pulse_mode(pulse_mode), .bypass(bypass), .scale(scale), .pulse_in(pulse_in), .tick(tick)
);

// File: tb/tb_strobe_prescaler.sv
module tb_strobe_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [3:0] src_en = '0;
  logic [1:0] clk_sel = '0;
  logic       pulse_mode = 1'b0;
  logic       bypass = 1'b0;
  logic [3:0] scale = '0;
  logic       pulse_in = 1'b0;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int nt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strobe_prescaler dut (
    .clk(clk), .rst_n(rst_n), .run(run), .src_en(src_en), .clk_sel(clk_sel),
    .pulse_mode(pulse_mode), .bypass(bypass), .scale(scale), .pulse_in(pulse_in), .tick(tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (tick) nt++;
  endtask

  task automatic strobe(input int sel);
    src_en = 4'b1 << sel;
    cyc();
    src_en = '0;
    cyc();
  endtask

  task automatic cfg(input bit pm, input bit byp, input int n, input int sel);
    run = 1'b0;
    pulse_in = 1'b0;
    pulse_mode = pm;
    bypass = byp;
    scale = 4'(n);
    clk_sel = 2'(sel);
    cyc();
    run = 1'b1;
    cyc();
    nt = 0;
  endtask

  task automatic t_reset();
    chk(tick == 1'b0, "R1 tick after reset", int'(tick), 0);
    cfg(0, 1, 0, 0);
    run = 1'b0;
    cyc();
    nt = 0;
    strobe(0);
    chk(nt == 0, "R1 no tick while disabled", nt, 0);
  endtask

  task automatic t_divide(input int n);
    int p = 2 << n;
    cfg(0, 0, n, 1);
    repeat (p - 1) strobe(1);
    chk(nt == 0, "R3 before first period", nt, 0);
    strobe(1);
    chk(nt == 1, "R3 first period", nt, 1);
    repeat (2 * p) strobe(1);
    chk(nt == 3, "R3 three periods", nt, 3);
  endtask

  task automatic t_select();
    cfg(0, 0, 0, 2);
    repeat (6) begin strobe(0); strobe(1); strobe(3); end
    chk(nt == 0, "R2 other sources ignored", nt, 0);
    strobe(2);
    strobe(2);
    chk(nt == 1, "R2 selected source counts", nt, 1);
  endtask

  task automatic t_bypass_time();
    cfg(0, 1, 7, 3);
    for (int i = 0; i < 5; i++) begin
      src_en = 4'b1000;
      cyc();
      chk(nt == i + 1, "R4 tick cycle after strobe", nt, i + 1);
      src_en = '0;
      cyc();
    end
    src_en = 4'b1000;
    cyc(); cyc(); cyc();
    src_en = '0;
    cyc();
    chk(nt == 8, "R4 back-to-back strobes", nt, 8);
  endtask

  task automatic t_restart();
    cfg(0, 0, 2, 0);
    repeat (5) strobe(0);
    run = 1'b0;
    cyc();
    run = 1'b1;
    cyc();
    repeat (7) strobe(0);
    chk(nt == 0, "R1 count cleared by disable", nt, 0);
    strobe(0);
    chk(nt == 1, "R1 full period after enable", nt, 1);
  endtask

  task automatic t_pulse_direct(input bit byp, input int n, input string req);
    cfg(1, byp, n, 0);
    for (int i = 0; i < 4; i++) begin
      pulse_in = 1'b1;
      cyc();
      chk(nt == i + 1, req, nt, i + 1);
      cyc(); cyc();
      chk(nt == i + 1, "R10 single-cycle tick", nt, i + 1);
      pulse_in = 1'b0;
      cyc(); cyc();
    end
  endtask

  task automatic t_filter(input int n);
    int e = 1 << n;
    cfg(1, 0, n, 1);
    pulse_in = 1'b1;
    repeat (e - 1) strobe(1);
    chk(nt == 0, "R7 rise not yet accepted", nt, 0);
    src_en = 4'b0010;
    cyc();
    chk(nt == 1, "R7 tick after last strobe", nt, 1);
    src_en = '0;
    cyc();
    chk(nt == 1, "R10 filter tick single", nt, 1);
    pulse_in = 1'b0;
    repeat (e) strobe(1);
    chk(nt == 1, "R9 fall gives no tick", nt, 1);
    pulse_in = 1'b1;
    repeat (e - 1) strobe(1);
    chk(nt == 1, "R9 new rise needs full count", nt, 1);
    strobe(1);
    chk(nt == 2, "R9 new rise accepted", nt, 2);
  endtask

  task automatic t_glitch();
    cfg(1, 0, 2, 1);
    pulse_in = 1'b1;
    repeat (3) strobe(1);
    pulse_in = 1'b0;
    cyc();
    pulse_in = 1'b1;
    repeat (3) strobe(1);
    chk(nt == 0, "R8 count restarted by glitch", nt, 0);
    strobe(1);
    chk(nt == 1, "R8 accepted after full count", nt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_divide(0);
    t_divide(2);
    t_divide(5);
    t_select();
    t_bypass_time();
    t_restart();
    t_pulse_direct(1'b1, 3, "R5 bypass edge tick");
    t_pulse_direct(1'b0, 0, "R6 zero width acts as bypass");
    t_filter(2);
    t_filter(4);
    t_glitch();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule